// File: doc/BRIEF.md
# Prioritised Interrupt and Data-Channel Request Node

One instance of this node lives in every peripheral controller attached to a shared I/O bus. It keeps the device's Busy and Done flags, an interrupt mask bit and a 4-bit priority level that software writes. It turns them into a program-interrupt request and a data-channel (DMA) request. Both requests are active-high and are meant to be ORed with the requests of every other node before they reach the CPU. The node takes its requests from its raw conditions only when the CPU broadcasts a Request Enable strobe, so all nodes arbitrate on the same snapshot.

Arbitration is positional. Each request type has its own priority chain. A node whose request is up pulls its chain output low, which blocks every node further from the CPU. With no request, the node passes the chain input straight through. When the CPU issues an address-request strobe, the data-channel winner presents its memory address. The winner is the node whose request is up and whose chain input is high. The address leaves on a valid/ready stream. After each accepted word the address register steps up by one and the block counter steps down by one. When the count runs out, the node ends the transfer and raises Done.

The address stream obeys back-pressure. Once `dma_addr_valid_o` is high, it and `dma_addr_o` stay unchanged until a cycle in which `dma_addr_ready_i` is also high. At most one word is outstanding at a time.

Top module: `irq_dma_node`

## Requirements
- R1: Reset (`rst_n` low) and a synchronous `clr_i` pulse set Busy, Done, mask, level, address and count to zero, drop both requests and the address valid. In that state each chain output equals its chain input.
- R2: A write (`wr_en_i` high for one cycle) selects its target with `wr_sel_i`: 0 sets the level from `wr_data_i[3:0]`, 1 sets the mask from `wr_data_i[0]`, 2 loads the address register and 3 loads the block counter, each from `wr_data_i[14:0]`.
- R3: `ctl_start_i` sets Busy and clears Done. `ctl_idle_i` clears both flags. `dev_done_i` clears Busy and sets Done. If several of these are high together, `dev_done_i` wins over `ctl_idle_i`, and `ctl_idle_i` wins over `ctl_start_i`.
- R4: An interrupt is pending when Done is set, the mask is clear and the level is greater than `sys_level_i`, compared as unsigned numbers (15 is the highest). A level equal to the system level does not qualify.
- R5: `int_req_o` rises only in the cycle after a `req_sync_i` strobe that samples a pending interrupt. A condition that becomes pending between strobes raises no request.
- R6: The interrupt request is withdrawn as soon as the pending condition goes away: Done cleared, mask set, or system level raised to the node's level or above. It returns only at a later strobe.
- R7: For each chain, the chain output is low while that chain's request is up. Otherwise the chain output equals the chain input.
- R8: A data-channel transfer is pending while Busy is set and the block count is non-zero. The pending transfer drives `dch_req_o` after a `req_sync_i` strobe.
- R9: An `addr_req_i` strobe raises `dma_addr_valid_o` in the next cycle, carrying the address register, only if `dch_req_o` and `dch_pri_in_i` are both high at the strobe. Otherwise the strobe does nothing.
- R10: While `dma_addr_valid_o` is high and `dma_addr_ready_i` is low, valid and the address hold steady.
- R11: On an accepted word the address increments (wrapping at 15 bits) and the count decrements. `dch_req_o` drops until the next strobe. When the count reaches zero, Busy clears and Done sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous bus clear |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 15 | Write data |
| ctl_start_i | input | 1 | Set Busy, clear Done |
| ctl_idle_i | input | 1 | Clear Busy and Done |
| dev_done_i | input | 1 | Device finished: clear Busy, set Done |
| sys_level_i | input | 4 | System priority level from the CPU |
| req_sync_i | input | 1 | Request Enable strobe |
| addr_req_i | input | 1 | Address-request strobe |
| int_pri_in_i | input | 1 | Interrupt chain input |
| int_pri_out_o | output | 1 | Interrupt chain output |
| int_req_o | output | 1 | Interrupt request to the wired-OR line |
| dch_pri_in_i | input | 1 | Data-channel chain input |
| dch_pri_out_o | output | 1 | Data-channel chain output |
| dch_req_o | output | 1 | Data-channel request to the wired-OR line |
| dma_addr_valid_o | output | 1 | Address word valid |
| dma_addr_ready_i | input | 1 | Address word accepted |
| dma_addr_o | output | 15 | DMA memory address |

## Verification
A table of level, system level, mask and Done combinations exercises the interrupt condition. The table covers a level above, equal to and below the system level, the extreme levels 0 and 15, and a masked case and a Done-clear case. These separate a strict comparison from a non-strict one and show whether mask and Done are honoured. Directed sequences make the pending condition appear and disappear between strobes, which separates synchronised requests from free-running ones. A two-word block starting at 0x7FFE shows increment, wraparound and end-of-block Done. That block is run with the chain input low, and with ready held low, to separate winner-only address output and stall behaviour.

// File: rtl/irq_dma_node_pkg.sv
package irq_dma_node_pkg;
  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_ADDR  = 2'd2,
    SEL_COUNT = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/idn_flags.sv
module idn_flags
  import irq_dma_node_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic             ctl_start_i,
  input  logic             ctl_idle_i,
  input  logic             dev_done_i,
  input  logic             blk_end_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mask_o,
  output logic [LVL_W-1:0] level_o
);
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0; done_o <= 1'b0; mask_o <= 1'b0; level_o <= '0;
    end else if (clr_i) begin
      busy_o <= 1'b0; done_o <= 1'b0; mask_o <= 1'b0; level_o <= '0;
    end else begin
      if (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_LEVEL) level_o <= wr_lvl_i;
      if (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_MASK)  mask_o  <= wr_lvl_i[0];
      if (dev_done_i || blk_end_i) begin
        busy_o <= 1'b0; done_o <= 1'b1;
      end else if (ctl_idle_i) begin
        busy_o <= 1'b0; done_o <= 1'b0;
      end else if (ctl_start_i) begin
        busy_o <= 1'b1; done_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/idn_chain_slot.sv
module idn_chain_slot (
  input  logic clk_i,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sync_i,
  input  logic pend_i,
  input  logic drop_i,
  input  logic pri_in_i,
  output logic req_o,
  output logic pri_out_o
);
  logic held_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                held_q <= 1'b0;
    else if (clr_i || drop_i)  held_q <= 1'b0;
    else if (sync_i)           held_q <= pend_i;
    else                       held_q <= held_q & pend_i;
  end
  assign req_o     = held_q & pend_i;
  assign pri_out_o = pri_in_i & ~req_o;
endmodule

// File: rtl/idn_dma.sv
module idn_dma
  import irq_dma_node_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              win_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cnt_nz_o,
  output logic              accept_o,
  output logic              blk_end_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  logic [ADDR_W-1:0] cnt_q;

  assign cnt_nz_o  = |cnt_q;
  assign accept_o  = valid_o & ready_i;
  assign blk_end_o = accept_o & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0; cnt_q <= '0; valid_o <= 1'b0;
    end else if (clr_i) begin
      addr_o <= '0; cnt_q <= '0; valid_o <= 1'b0;
    end else if (accept_o) begin
      addr_o  <= addr_o + ONE;
      cnt_q   <= cnt_q - ONE;
      valid_o <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_ADDR)  addr_o <= wr_data_i;
      if (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_COUNT) cnt_q  <= wr_data_i;
      if (win_i) valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_dma_node.sv
module irq_dma_node #(
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              ctl_start_i,
  input  logic              ctl_idle_i,
  input  logic              dev_done_i,
  input  logic [LVL_W-1:0]  sys_level_i,
  input  logic              req_sync_i,
  input  logic              addr_req_i,
  input  logic              int_pri_in_i,
  output logic              int_pri_out_o,
  output logic              int_req_o,
  input  logic              dch_pri_in_i,
  output logic              dch_pri_out_o,
  output logic              dch_req_o,
  output logic              dma_addr_valid_o,
  input  logic              dma_addr_ready_i,
  output logic [ADDR_W-1:0] dma_addr_o
);
  logic             busy_q, done_q, mask_q;
  logic [LVL_W-1:0] level_q;
  logic             cnt_nz, accept, blk_end;
  logic             int_pend, dch_pend, dch_win;

  idn_flags #(.LVL_W(LVL_W)) u_flags (
    .clk_i, .rst_n, .clr_i, .wr_en_i, .wr_sel_i,
    .wr_lvl_i(wr_data_i[LVL_W-1:0]),
    .ctl_start_i, .ctl_idle_i, .dev_done_i,
    .blk_end_i(blk_end),
    .busy_o(busy_q), .done_o(done_q), .mask_o(mask_q), .level_o(level_q)
  );

  assign int_pend = done_q & ~mask_q & (level_q > sys_level_i);
  assign dch_pend = busy_q & cnt_nz;

  idn_chain_slot u_int_slot (
    .clk_i, .rst_n, .clr_i, .sync_i(req_sync_i), .pend_i(int_pend),
    .drop_i(1'b0), .pri_in_i(int_pri_in_i),
    .req_o(int_req_o), .pri_out_o(int_pri_out_o)
  );

  idn_chain_slot u_dch_slot (
    .clk_i, .rst_n, .clr_i, .sync_i(req_sync_i), .pend_i(dch_pend),
    .drop_i(accept), .pri_in_i(dch_pri_in_i),
    .req_o(dch_req_o), .pri_out_o(dch_pri_out_o)
  );

  assign dch_win = addr_req_i & dch_req_o & dch_pri_in_i & ~dma_addr_valid_o;

  idn_dma #(.ADDR_W(ADDR_W)) u_dma (
    .clk_i, .rst_n, .clr_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .win_i(dch_win), .ready_i(dma_addr_ready_i),
    .valid_o(dma_addr_valid_o), .addr_o(dma_addr_o),
    .cnt_nz_o(cnt_nz), .accept_o(accept), .blk_end_o(blk_end)
  );
endmodule

// File: rtl/idn_checker.sv
module idn_checker #(
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              clr_i,
  input logic              int_req_o,
  input logic              int_pri_out_o,
  input logic              dch_req_o,
  input logic              dch_pri_in_i,
  input logic              dch_pri_out_o,
  input logic              addr_req_i,
  input logic              dma_addr_valid_o,
  input logic              dma_addr_ready_i,
  input logic [ADDR_W-1:0] dma_addr_o,
  input logic              done_q,
  input logic              mask_q,
  input logic              busy_q,
  input logic [LVL_W-1:0]  level_q,
  input logic [LVL_W-1:0]  sys_level_i
);
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> !int_req_o && !dch_req_o && !dma_addr_valid_o); // R1
  AST_INT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_n)
    int_req_o |-> done_q && !mask_q && (level_q > sys_level_i)); // R4
  AST_INT_CHAIN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    int_req_o |-> !int_pri_out_o); // R7
  AST_DCH_CHAIN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    dch_req_o |-> !dch_pri_out_o); // R7
  AST_DCH_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    dch_req_o |-> busy_q); // R8
  AST_VALID_FROM_WIN: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(dma_addr_valid_o) |-> $past(addr_req_i && dch_req_o && dch_pri_in_i)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n || clr_i)
    dma_addr_valid_o && !dma_addr_ready_i |=> dma_addr_valid_o && $stable(dma_addr_o)); // R10
  AST_ACCEPT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    dma_addr_valid_o && dma_addr_ready_i |=> !dch_req_o && !dma_addr_valid_o); // R11
endmodule

bind irq_dma_node idn_checker #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .clr_i(clr_i),
  .int_req_o(int_req_o), .int_pri_out_o(int_pri_out_o),
  .dch_req_o(dch_req_o), .dch_pri_in_i(dch_pri_in_i), .dch_pri_out_o(dch_pri_out_o),
  .addr_req_i(addr_req_i), .dma_addr_valid_o(dma_addr_valid_o),
  .dma_addr_ready_i(dma_addr_ready_i), .dma_addr_o(dma_addr_o),
  .done_q(done_q), .mask_q(mask_q), .busy_q(busy_q), .level_q(level_q),
  .sys_level_i(sys_level_i)
);

// File: tb/sim_irq_dma_node.sv
module sim_irq_dma_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, wr_en = 0, start = 0, idle = 0, ddone = 0;
  logic sync = 0, areq = 0, ipin = 1, dpin = 1, ready = 0;
  logic [1:0] wsel = '0;
  logic [14:0] wdata = '0;
  logic [3:0] sysl = '0;
  logic ipout, ireq, dpout, dreq, avalid;
  logic [14:0] addr;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  irq_dma_node u0 (
    .clk_i(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(wr_en), .wr_sel_i(wsel),
    .wr_data_i(wdata), .ctl_start_i(start), .ctl_idle_i(idle), .dev_done_i(ddone),
    .sys_level_i(sysl), .req_sync_i(sync), .addr_req_i(areq),
    .int_pri_in_i(ipin), .int_pri_out_o(ipout), .int_req_o(ireq),
    .dch_pri_in_i(dpin), .dch_pri_out_o(dpout), .dch_req_o(dreq),
    .dma_addr_valid_o(avalid), .dma_addr_ready_i(ready), .dma_addr_o(addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [14:0] d);
    @(negedge clk); wr_en = 1; wsel = s; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse_sync(); @(negedge clk); sync = 1; @(negedge clk); sync = 0; endtask
  task automatic pulse_areq(); @(negedge clk); areq = 1; @(negedge clk); areq = 0; endtask
  task automatic pulse_done(); @(negedge clk); ddone = 1; @(negedge clk); ddone = 0; endtask
  task automatic pulse_idle(); @(negedge clk); idle = 1; @(negedge clk); idle = 0; endtask
  task automatic pulse_start(); @(negedge clk); start = 1; @(negedge clk); start = 0; endtask

  // level, system level, mask, done, expected request
  typedef struct packed { logic [3:0] lvl; logic [3:0] sl; logic m; logic d; logic e; } vec_t;
  localparam vec_t VECS [8] = '{
    '{4'd5, 4'd3, 1'b0, 1'b1, 1'b1},
    '{4'd3, 4'd3, 1'b0, 1'b1, 1'b0},
    '{4'd2, 4'd3, 1'b0, 1'b1, 1'b0},
    '{4'd15, 4'd14, 1'b0, 1'b1, 1'b1},
    '{4'd0, 4'd0, 1'b0, 1'b1, 1'b0},
    '{4'd9, 4'd0, 1'b1, 1'b1, 1'b0},
    '{4'd9, 4'd0, 1'b0, 1'b0, 1'b0},
    '{4'd1, 4'd0, 1'b0, 1'b1, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 int_req", ireq, 0); chk("R1 dch_req", dreq, 0); chk("R1 valid", avalid, 0);
    chk("R1 int chain pass", ipout, 1); chk("R1 dch chain pass", dpout, 1);
    rst_n = 1;

    // R4 table walk, also R2 level/mask writes and R3 done/idle
    foreach (VECS[i]) begin
      pulse_idle();
      wr(2'd0, {11'd0, VECS[i].lvl});
      wr(2'd1, {14'd0, VECS[i].m});
      if (VECS[i].d) pulse_done();
      sysl = VECS[i].sl;
      pulse_sync();
      chk("R4 int_req", ireq, VECS[i].e);
      chk("R7 int chain", ipout, !VECS[i].e);
    end

    // R5 pending between strobes raises nothing
    pulse_idle(); sync = 0;
    wr(2'd0, 15'd7); wr(2'd1, 15'd0); sysl = 4'd0;
    pulse_done();
    @(negedge clk);
    chk("R5 no strobe", ireq, 0);
    pulse_sync();
    chk("R5 after strobe", ireq, 1);
    // R7 blocked chain with input low
    ipin = 0; #1; chk("R7 chain low in", ipout, 0); ipin = 1;
    // R6 mask withdraw, return only on strobe
    wr(2'd1, 15'd1); chk("R6 mask withdraw", ireq, 0);
    wr(2'd1, 15'd0); chk("R6 no return w/o strobe", ireq, 0);
    pulse_sync(); chk("R6 return on strobe", ireq, 1);
    sysl = 4'd7; #1; chk("R6 sys level raise", ireq, 0);
    sysl = 4'd0; pulse_sync(); chk("R6 re-sync", ireq, 1);
    pulse_idle(); chk("R6 done cleared", ireq, 0);

    // R3 priority: dev_done over start
    @(negedge clk); start = 1; ddone = 1; @(negedge clk); start = 0; ddone = 0;
    pulse_sync(); chk("R3 done wins", ireq, 1);

    // DMA block of two words from 0x7FFE
    pulse_idle();
    wr(2'd2, 15'h7FFE); wr(2'd3, 15'd2);
    pulse_start();
    chk("R8 no strobe", dreq, 0);
    pulse_sync();
    chk("R8 dch_req", dreq, 1); chk("R7 dch chain block", dpout, 0);
    dpin = 0; pulse_areq(); chk("R9 not winner", avalid, 0); dpin = 1;
    pulse_areq();
    chk("R9 valid", avalid, 1); chk("R2 R9 address", addr, 15'h7FFE);
    repeat (3) @(negedge clk);
    chk("R10 hold valid", avalid, 1); chk("R10 hold addr", addr, 15'h7FFE);
    ready = 1; @(negedge clk); ready = 0;
    chk("R11 valid drop", avalid, 0); chk("R11 dch drop", dreq, 0);
    pulse_sync(); chk("R11 resync", dreq, 1);
    pulse_areq(); chk("R11 increment", addr, 15'h7FFF);
    ready = 1; @(negedge clk); ready = 0;
    pulse_sync(); chk("R11 block end no dch", dreq, 0);
    chk("R11 done set", ireq, 1);
    // wrap check
    wr(2'd3, 15'd1); pulse_start(); pulse_sync(); pulse_areq();
    chk("R11 wrap", addr, 15'h0000);
    // R1 clear during valid
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    chk("R1 clear valid", avalid, 0); chk("R1 clear dch", dreq, 0);
    pulse_done(); pulse_sync(); chk("R1 level cleared", ireq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule